// File: doc/BRIEF.md
# Coverage-Class Response Timing Unit

This block produces the wireless MAC response-timing values for the channel mode in use and the configured coverage class, and it times one ACK or CTS wait at a time. Three mode flags (5 GHz band, CCK modulation, turbo) select the core clock rate, the base slot time and the SIFS. The coverage class stretches the slot time. The unit converts the slot time and the response timeout from microseconds into core clock cycles and holds them in fixed-width fields.

A transmit controller pulses a start input when it needs an ACK or a CTS. The unit loads a down-counter from the matching cycle field. If no response pulse arrives before the count runs out, it raises a one-cycle expiry pulse. A converted value that cannot fit its field is refused. The field keeps its earlier contents and an error flag is raised.

Top module: `covclass_timer`

## Requirements
- R1: The core clock rate in MHz is 40 when the 5 GHz flag is set, otherwise 22 when the CCK flag is set, otherwise 44. The rate is doubled when the turbo flag is set. The 5 GHz flag wins over CCK.
- R2: The slot time in microseconds is the base slot plus three times the coverage class. The base slot is 6 under turbo, otherwise 20 under CCK, otherwise 9. `slot_cyc` equals the slot time multiplied by the clock rate.
- R3: The response timeout in microseconds is the SIFS plus the slot time. The SIFS is 8 under turbo, otherwise 16 under 5 GHz, otherwise 10. `ack_cyc` equals the timeout multiplied by the clock rate, and `cts_cyc` always equals `ack_cyc`.
- R4: The 14-bit timeout fields accept a timeout T only when floor(16383 / rate) > T. Otherwise `tmo_err` is 1 and `ack_cyc` and `cts_cyc` keep their previous values. `tmo_err` returns to 0 once an accepted value is computed.
- R5: The 16-bit slot field accepts a slot time S only when floor(65535 / rate) > S. Otherwise `slot_err` is 1 and `slot_cyc` keeps its previous value.
- R6: A change of mode flags or coverage class shows on the outputs one clock cycle later.
- R7: A `wait_start` pulse loads the down-counter from `cts_cyc` when `wait_cts` is 1, and from `ack_cyc` when `wait_cts` is 0. `wait_busy` goes high in the next cycle. For a loaded value N, `wait_expired` is high for exactly one cycle, N cycles after the start edge, and `wait_busy` is low from then on.
- R8: A `resp_seen` pulse during a wait ends it: `wait_busy` falls in the next cycle and no expiry follows.
- R9: Changing the mode or coverage class during a wait does not alter the wait's length.
- R10: A `wait_start` during a wait restarts the count from the full field value.
- R11: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_5g | input | 1 | Channel is in the 5 GHz band |
| chan_cck | input | 1 | Channel uses CCK modulation |
| chan_turbo | input | 1 | Turbo (double clock) mode |
| cov_class | input | COV_W (8) | Coverage class |
| wait_start | input | 1 | Pulse: begin a response wait |
| wait_cts | input | 1 | Wait kind: 1 = CTS, 0 = ACK |
| resp_seen | input | 1 | Pulse: expected response received |
| slot_cyc | output | SLOT_W (16) | Slot time in cycles |
| ack_cyc | output | TMO_W (14) | ACK timeout in cycles |
| cts_cyc | output | TMO_W (14) | CTS timeout in cycles |
| slot_err | output | 1 | Last slot value refused |
| tmo_err | output | 1 | Last timeout value refused |
| wait_busy | output | 1 | A wait is in progress |
| wait_expired | output | 1 | One-cycle pulse: wait ran out |

## Verification
On every cycle, the assertions check these properties:
- The expiry is a single-cycle pulse and never overlaps a busy wait.
- A start always arms the counter.
- A response during a wait cancels it.
- Refused values leave their fields unchanged.
- The two timeout fields stay equal.

Only the bench scenarios can show the following:
- The arithmetic of the mode tables under each flag mix.
- The exact refusal boundary at coverage classes 57/58 and 245/246.
- The exact cycle on which an expiry lands.
- That a configuration change or a restart in the middle of a wait moves, or leaves alone, that cycle.

// File: rtl/covclass_pkg.sv
package covclass_pkg;

    localparam int unsigned MHZ_W = 7;
    localparam int unsigned BASE_W = 5;

    localparam logic [MHZ_W-1:0] RATE_5G    = 7'd40;
    localparam logic [MHZ_W-1:0] RATE_CCK   = 7'd22;
    localparam logic [MHZ_W-1:0] RATE_OTHER = 7'd44;

    localparam logic [BASE_W-1:0] SLOT_TURBO = 5'd6;
    localparam logic [BASE_W-1:0] SLOT_CCK   = 5'd20;
    localparam logic [BASE_W-1:0] SLOT_OTHER = 5'd9;

    localparam logic [BASE_W-1:0] SIFS_TURBO = 5'd8;
    localparam logic [BASE_W-1:0] SIFS_5G    = 5'd16;
    localparam logic [BASE_W-1:0] SIFS_OTHER = 5'd10;

    typedef struct packed {
        logic band5;
        logic cck;
        logic turbo;
    } chan_mode_t;

endpackage

// File: rtl/covclass_rates.sv
module covclass_rates
    import covclass_pkg::*;
(
    input  chan_mode_t              mode,
    output logic [MHZ_W-1:0]        rate_mhz,
    output logic [BASE_W-1:0]       slot_base_us,
    output logic [BASE_W-1:0]       sifs_us
);

    logic [MHZ_W-1:0] base_rate;

    always_comb begin
        if (mode.band5) begin
            base_rate = RATE_5G;
        end else if (mode.cck) begin
            base_rate = RATE_CCK;
        end else begin
            base_rate = RATE_OTHER;
        end
        rate_mhz = mode.turbo ? (base_rate << 1) : base_rate;

        if (mode.turbo) begin
            slot_base_us = SLOT_TURBO;
        end else if (mode.cck) begin
            slot_base_us = SLOT_CCK;
        end else begin
            slot_base_us = SLOT_OTHER;
        end

        if (mode.turbo) begin
            sifs_us = SIFS_TURBO;
        end else if (mode.band5) begin
            sifs_us = SIFS_5G;
        end else begin
            sifs_us = SIFS_OTHER;
        end
    end

endmodule

// File: rtl/covclass_prog.sv
module covclass_prog
    import covclass_pkg::*;
#(
    parameter int unsigned COV_W  = 8,
    parameter int unsigned SLOT_W = 16,
    parameter int unsigned TMO_W  = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COV_W-1:0]    cov_class,
    input  logic [MHZ_W-1:0]    rate_mhz,
    input  logic [BASE_W-1:0]   slot_base_us,
    input  logic [BASE_W-1:0]   sifs_us,
    output logic [SLOT_W-1:0]   slot_cyc,
    output logic [TMO_W-1:0]    ack_cyc,
    output logic [TMO_W-1:0]    cts_cyc,
    output logic                slot_err,
    output logic                tmo_err
);

    localparam int unsigned US_W   = COV_W + 4;
    localparam int unsigned RAW_W  = US_W + MHZ_W + 1;
    localparam int unsigned PROD_W = (RAW_W > SLOT_W + 1) ? RAW_W : SLOT_W + 1;
    localparam logic [PROD_W-1:0] SLOT_MAX = PROD_W'((64'd1 << SLOT_W) - 64'd1);
    localparam logic [PROD_W-1:0] TMO_MAX  = PROD_W'((64'd1 << TMO_W) - 64'd1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [TMO_W-1:0]  ack;
        logic [TMO_W-1:0]  cts;
        logic              slot_bad;
        logic              tmo_bad;
    } prog_t;

    prog_t prog_d, prog_q;

    logic [US_W-1:0]   slot_us;
    logic [US_W-1:0]   tmo_us;
    logic [PROD_W-1:0] slot_prod;
    logic [PROD_W-1:0] slot_lim;
    logic [PROD_W-1:0] tmo_prod;
    logic [PROD_W-1:0] tmo_lim;
    logic              slot_fits;
    logic              tmo_fits;

    always_comb begin
        slot_us   = US_W'(slot_base_us) + (US_W'(cov_class) * US_W'(3));
        tmo_us    = slot_us + US_W'(sifs_us);
        slot_prod = PROD_W'(rate_mhz) * PROD_W'(slot_us);
        slot_lim  = slot_prod + PROD_W'(rate_mhz);
        tmo_prod  = PROD_W'(rate_mhz) * PROD_W'(tmo_us);
        tmo_lim   = tmo_prod + PROD_W'(rate_mhz);
        slot_fits = (slot_lim <= SLOT_MAX);
        tmo_fits  = (tmo_lim <= TMO_MAX);

        prog_d          = prog_q;
        prog_d.slot_bad = !slot_fits;
        prog_d.tmo_bad  = !tmo_fits;
        if (slot_fits) begin
            prog_d.slot = slot_prod[SLOT_W-1:0];
        end
        if (tmo_fits) begin
            prog_d.ack = tmo_prod[TMO_W-1:0];
            prog_d.cts = tmo_prod[TMO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else begin
            prog_q <= prog_d;
        end
    end

    assign slot_cyc = prog_q.slot;
    assign ack_cyc  = prog_q.ack;
    assign cts_cyc  = prog_q.cts;
    assign slot_err = prog_q.slot_bad;
    assign tmo_err  = prog_q.tmo_bad;

endmodule

// File: rtl/covclass_wait.sv
module covclass_wait #(
    parameter int unsigned TMO_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             use_cts,
    input  logic             resp,
    input  logic [TMO_W-1:0] ack_len,
    input  logic [TMO_W-1:0] cts_len,
    output logic             busy,
    output logic             expired
);

    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             busy;
        logic             fire;
    } wait_t;

    wait_t wait_d, wait_q;
    logic [TMO_W-1:0] load_len;

    always_comb begin
        load_len    = use_cts ? cts_len : ack_len;
        wait_d      = wait_q;
        wait_d.fire = 1'b0;
        if (start) begin
            wait_d.cnt  = (load_len == '0) ? ONE : load_len;
            wait_d.busy = 1'b1;
        end else if (wait_q.busy) begin
            if (resp) begin
                wait_d.cnt  = '0;
                wait_d.busy = 1'b0;
            end else if (wait_q.cnt == ONE) begin
                wait_d.cnt  = '0;
                wait_d.busy = 1'b0;
                wait_d.fire = 1'b1;
            end else begin
                wait_d.cnt = wait_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_d;
        end
    end

    assign busy    = wait_q.busy;
    assign expired = wait_q.fire;

endmodule

// File: rtl/covclass_timer.sv
module covclass_timer
    import covclass_pkg::*;
#(
    parameter int unsigned COV_W  = 8,
    parameter int unsigned SLOT_W = 16,
    parameter int unsigned TMO_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_5g,
    input  logic              chan_cck,
    input  logic              chan_turbo,
    input  logic [COV_W-1:0]  cov_class,
    input  logic              wait_start,
    input  logic              wait_cts,
    input  logic              resp_seen,
    output logic [SLOT_W-1:0] slot_cyc,
    output logic [TMO_W-1:0]  ack_cyc,
    output logic [TMO_W-1:0]  cts_cyc,
    output logic              slot_err,
    output logic              tmo_err,
    output logic              wait_busy,
    output logic              wait_expired
);

    chan_mode_t         mode;
    logic [MHZ_W-1:0]   rate_mhz;
    logic [BASE_W-1:0]  slot_base_us;
    logic [BASE_W-1:0]  sifs_us;

    assign mode = '{band5: chan_5g, cck: chan_cck, turbo: chan_turbo};

    covclass_rates u_rates (
        .mode         (mode),
        .rate_mhz     (rate_mhz),
        .slot_base_us (slot_base_us),
        .sifs_us      (sifs_us)
    );

    covclass_prog #(
        .COV_W  (COV_W),
        .SLOT_W (SLOT_W),
        .TMO_W  (TMO_W)
    ) u_prog (
        .clk          (clk),
        .rst_n        (rst_n),
        .cov_class    (cov_class),
        .rate_mhz     (rate_mhz),
        .slot_base_us (slot_base_us),
        .sifs_us      (sifs_us),
        .slot_cyc     (slot_cyc),
        .ack_cyc      (ack_cyc),
        .cts_cyc      (cts_cyc),
        .slot_err     (slot_err),
        .tmo_err      (tmo_err)
    );

    covclass_wait #(
        .TMO_W (TMO_W)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wait_start),
        .use_cts (wait_cts),
        .resp    (resp_seen),
        .ack_len (ack_cyc),
        .cts_len (cts_cyc),
        .busy    (wait_busy),
        .expired (wait_expired)
    );

endmodule

// File: rtl/covclass_timer_chk.sv
module covclass_timer_chk #(
    parameter int unsigned SLOT_W = 16,
    parameter int unsigned TMO_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wait_start,
    input logic              resp_seen,
    input logic [SLOT_W-1:0] slot_cyc,
    input logic [TMO_W-1:0]  ack_cyc,
    input logic [TMO_W-1:0]  cts_cyc,
    input logic              slot_err,
    input logic              tmo_err,
    input logic              wait_busy,
    input logic              wait_expired
);

    a_r3_fields_equal: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cyc == cts_cyc);

    a_r4_hold_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> $stable(ack_cyc));

    a_r5_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |-> $stable(slot_cyc));

    a_r7_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        wait_start |=> wait_busy);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wait_expired |=> !wait_expired);

    a_r7_expiry_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wait_expired |-> !wait_busy);

    a_r8_resp_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_busy && resp_seen && !wait_start) |=> (!wait_busy && !wait_expired));

endmodule

bind covclass_timer covclass_timer_chk #(
    .SLOT_W (SLOT_W),
    .TMO_W  (TMO_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_start   (wait_start),
    .resp_seen    (resp_seen),
    .slot_cyc     (slot_cyc),
    .ack_cyc      (ack_cyc),
    .cts_cyc      (cts_cyc),
    .slot_err     (slot_err),
    .tmo_err      (tmo_err),
    .wait_busy    (wait_busy),
    .wait_expired (wait_expired)
);

// File: tb/covclass_timer_test.sv
module covclass_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_5g = 1'b0, chan_cck = 1'b0, chan_turbo = 1'b0;
    logic [7:0]  cov_class = 8'd0;
    logic        wait_start = 1'b0, wait_cts = 1'b0, resp_seen = 1'b0;
    logic [15:0] slot_cyc;
    logic [13:0] ack_cyc, cts_cyc;
    logic        slot_err, tmo_err, wait_busy, wait_expired;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    covclass_timer uut (
        .clk(clk), .rst_n(rst_n), .chan_5g(chan_5g), .chan_cck(chan_cck),
        .chan_turbo(chan_turbo), .cov_class(cov_class), .wait_start(wait_start),
        .wait_cts(wait_cts), .resp_seen(resp_seen), .slot_cyc(slot_cyc),
        .ack_cyc(ack_cyc), .cts_cyc(cts_cyc), .slot_err(slot_err),
        .tmo_err(tmo_err), .wait_busy(wait_busy), .wait_expired(wait_expired)
    );

    typedef struct packed {
        logic       m5;
        logic       cck;
        logic       turbo;
        logic [7:0] cov;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 8'd0},
        '{1'b1, 1'b0, 1'b0, 8'd0},
        '{1'b0, 1'b1, 1'b0, 8'd0},
        '{1'b1, 1'b0, 1'b1, 8'd2},
        '{1'b0, 1'b1, 1'b1, 8'd5},
        '{1'b0, 1'b0, 1'b1, 8'd57},
        '{1'b0, 1'b0, 1'b1, 8'd58},
        '{1'b0, 1'b0, 1'b0, 8'd255},
        '{1'b0, 1'b0, 1'b1, 8'd246},
        '{1'b1, 1'b1, 1'b0, 8'd3}
    };

    // model state of the programmed fields
    int m_slot = 0, m_tmo = 0;
    bit m_slot_err = 0, m_tmo_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_update(input bit m5, input bit cck, input bit tb, input int cov);
        int rate, sbase, sifs, slot_us, tmo_us;
        rate  = m5 ? 40 : (cck ? 22 : 44);
        if (tb) rate = rate * 2;
        sbase = tb ? 6 : (cck ? 20 : 9);
        sifs  = tb ? 8 : (m5 ? 16 : 10);
        slot_us = sbase + 3 * cov;
        tmo_us  = sifs + slot_us;
        m_slot_err = !((65535 / rate) > slot_us);
        m_tmo_err  = !((16383 / rate) > tmo_us);
        if (!m_slot_err) m_slot = slot_us * rate;
        if (!m_tmo_err)  m_tmo  = tmo_us * rate;
    endtask

    task automatic set_cfg(input bit m5, input bit cck, input bit tb, input int cov);
        @(negedge clk);
        chan_5g = m5; chan_cck = cck; chan_turbo = tb; cov_class = 8'(cov);
        model_update(m5, cck, tb, cov);
        @(negedge clk);
    endtask

    task automatic check_fields(input string tag);
        chk(slot_cyc == 16'(m_slot), "R2", {tag, " slot_cyc"}, int'(slot_cyc), m_slot);
        chk(ack_cyc == 14'(m_tmo), "R3", {tag, " ack_cyc"}, int'(ack_cyc), m_tmo);
        chk(cts_cyc == ack_cyc, "R3", {tag, " cts_cyc"}, int'(cts_cyc), int'(ack_cyc));
        chk(tmo_err == m_tmo_err, "R4", {tag, " tmo_err"}, int'(tmo_err), int'(m_tmo_err));
        chk(slot_err == m_slot_err, "R5", {tag, " slot_err"}, int'(slot_err), int'(m_slot_err));
    endtask

    // pulse start; return just after the start edge
    task automatic pulse_start(input bit cts);
        @(negedge clk);
        wait_start = 1'b1; wait_cts = cts;
        @(negedge clk);
        wait_start = 1'b0;
    endtask

    // after the start edge, expect expiry exactly n edges later
    task automatic expect_expiry(input int n, input string req);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (wait_expired || !wait_busy) early++;
        end
        chk(early == 0, req, "no early expiry", early, 0);
        @(negedge clk);
        chk(wait_expired == 1'b1, req, "expiry on cycle N", int'(wait_expired), 1);
        chk(wait_busy == 1'b0, req, "idle at expiry", int'(wait_busy), 0);
        @(negedge clk);
        chk(wait_expired == 1'b0, req, "expiry lasts one cycle", int'(wait_expired), 0);
    endtask

    initial begin
        int n0, seen;
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(slot_cyc == 0 && ack_cyc == 0 && cts_cyc == 0, "R11", "fields in reset",
            int'(slot_cyc) + int'(ack_cyc), 0);
        chk(!slot_err && !tmo_err && !wait_busy && !wait_expired, "R11", "flags in reset",
            int'(slot_err) + int'(tmo_err) + int'(wait_busy) + int'(wait_expired), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 table walk; each sample is one cycle after the change
        for (int v = 0; v < NVEC; v++) begin
            set_cfg(VECS[v].m5, VECS[v].cck, VECS[v].turbo, int'(VECS[v].cov));
            check_fields($sformatf("R1 R6 vec%0d", v));
        end

        // R4 boundary: cov 57 accepted, 58 refused with value held
        set_cfg(1'b0, 1'b0, 1'b1, 57);
        chk(ack_cyc == 14'd16280 && !tmo_err, "R4", "cov57 accepted", int'(ack_cyc), 16280);
        set_cfg(1'b0, 1'b0, 1'b1, 58);
        chk(ack_cyc == 14'd16280 && tmo_err, "R4", "cov58 refused holds", int'(ack_cyc), 16280);
        // R5 boundary: slot 245 accepted, 246 refused with value held
        set_cfg(1'b0, 1'b0, 1'b1, 245);
        chk(slot_cyc == 16'd65208 && !slot_err, "R5", "cov245 slot accepted", int'(slot_cyc), 65208);
        set_cfg(1'b0, 1'b0, 1'b1, 246);
        chk(slot_cyc == 16'd65208 && slot_err, "R5", "cov246 slot refused holds", int'(slot_cyc), 65208);

        // R7 plain ACK wait, CCK cov0: 30 us * 22 = 660 cycles
        set_cfg(1'b0, 1'b1, 1'b0, 0);
        check_fields("R7 setup");
        n0 = m_tmo;
        pulse_start(1'b0);
        chk(wait_busy == 1'b1, "R7", "busy after start", int'(wait_busy), 1);
        expect_expiry(n0, "R7");

        // R9 config change mid-wait, CTS kind
        pulse_start(1'b1);
        repeat (5) @(negedge clk);
        chan_5g = 1'b1; cov_class = 8'd9;
        model_update(1'b1, 1'b1, 1'b0, 9);
        for (int i = 6; i < n0; i++) begin
            @(negedge clk);
        end
        @(negedge clk);
        chk(wait_expired == 1'b1, "R9", "length unchanged by reconfig", int'(wait_expired), 1);
        check_fields("R9 new values");
        set_cfg(1'b0, 1'b1, 1'b0, 0);

        // R8 response cancels
        pulse_start(1'b0);
        repeat (10) @(negedge clk);
        resp_seen = 1'b1;
        @(negedge clk);
        resp_seen = 1'b0;
        chk(wait_busy == 1'b0, "R8", "busy drops after response", int'(wait_busy), 0);
        seen = 0;
        for (int i = 0; i < n0 + 5; i++) begin
            @(negedge clk);
            if (wait_expired) seen++;
        end
        chk(seen == 0, "R8", "no expiry after response", seen, 0);

        // R10 restart mid-wait
        pulse_start(1'b0);
        repeat (100) @(negedge clk);
        pulse_start(1'b0);
        expect_expiry(n0, "R10");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule